// File: doc/BRIEF.md
# Auto-Increment Register Load Interface

This block is the host-side loading port for a bank of nineteen 16-bit registers. A host drives an 8-bit bus, a strobe, a selector that marks each strobe as carrying an address or a data byte, and a byte selector. Each transfer happens when the strobe goes from high to low. The block presents the full bank contents in parallel to whatever logic reads them.

There are two ways to address the bank. In manual mode the host writes an address and then writes one byte, low or high as the byte selector picks. The address then stays where it is, so the next byte needs its own address write or goes to the same register. In auto mode one address write is enough. After it, every data strobe fills the current register, low byte first and then high byte. Once the high byte is written, the index moves to the next register. After the last register (index 18) it returns to the start address that was written, not to zero. This makes it possible to reload just the top part of the bank over and over. With auto mode, the whole bank takes 39 strobes instead of 57.

Top module: `reg_load_port`

## Requirements
- R1: After reset all nineteen registers read zero and the port is in manual mode, so a data strobe with no address write goes to register 0.
- R2: In manual mode, a strobe with the address/data selector at 0 and the byte selector at 0 stores the address. A later strobe with the selector at 1 writes the low byte (byte selector 0, bits 7:0) or the high byte (byte selector 1, bits 15:8) of that register. The address does not change.
- R3: In manual mode, data strobes while the stored address is 19 or above change no register.
- R4: Only a high-to-low transition of the strobe transfers anything. Raising the strobe or holding it high changes no register.
- R5: An address strobe with the byte selector at 1 enters auto mode. The address strobe itself writes no register.
- R6: In auto mode, data strobes alternate between the low byte and the high byte of the current register, starting with the low byte. The byte selector is ignored.
- R7: In auto mode the index steps by one after each high-byte write. After index 18 it returns to the start address.
- R8: In auto mode with a start address of 18, every pair of bytes goes to register 18. With a start address of 19 or above, no register is ever written.
- R9: Any address strobe, in either mode, replaces the index and the start address. It also restarts the byte order at the low byte, and its byte selector picks the new mode.
- R10: One address strobe followed by 38 data strobes programs all nineteen registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the strobe is sampled on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Transfer strobe; acts on its high-to-low transition |
| sel_data_i | input | 1 | 0 = address transfer, 1 = data transfer |
| sel_hi_i | input | 1 | Byte select for manual data; auto-mode select on address transfers |
| data_i | input | 8 | Address or data byte |
| regs_o | output | 304 | Register bank; register n occupies bits 16n+15 : 16n |

## Verification
If the index, the start address, the byte phase or the mode flag holds a wrong value, the damage shows on `regs_o` one clock after the next data strobe. A byte lands in the wrong register or the wrong half of a register, or lands where nothing should be written. A reference model in the bench tracks every register and is compared against the outputs on every clock, so a fault is reported on the cycle it first becomes visible. The directed sequences are built to make hidden-state faults visible: a wrap from 18 back to a nonzero start, a re-arm in the middle of a register pair, and out-of-range addresses.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    MODE_MANUAL = 1'b0,
    MODE_AUTO   = 1'b1
  } mode_e;

  // One byte-write request toward the register bank
  typedef struct packed {
    logic              wr;
    logic              hi;
    logic [BYTE_W-1:0] idx;
  } byte_wr_t;
endpackage

// File: rtl/lp_rst_sync.sv
module lp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/lp_addr_ctrl.sv
module lp_addr_ctrl
  import lp_pkg::*;
#(
  parameter int unsigned NREG = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              sel_data_i,
  input  logic              sel_hi_i,
  input  logic [BYTE_W-1:0] data_i,
  output byte_wr_t          wr_o,
  output mode_e             mode_o,
  output logic              hi_o,
  output logic [BYTE_W-1:0] addr_o,
  output logic [BYTE_W-1:0] start_o
);
  localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(NREG - 1);

  mode_e             mode_q, mode_d;
  logic              hi_q, hi_d;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] start_q, start_d;

  // next-state logic
  always_comb begin
    mode_d  = mode_q;
    hi_d    = hi_q;
    addr_d  = addr_q;
    start_d = start_q;
    wr_o    = '0;
    if (fall_i) begin
      if (!sel_data_i) begin
        addr_d  = data_i;
        start_d = data_i;
        mode_d  = sel_hi_i ? MODE_AUTO : MODE_MANUAL;
        hi_d    = 1'b0;
      end else if (mode_q == MODE_MANUAL) begin
        wr_o.wr  = 1'b1;
        wr_o.hi  = sel_hi_i;
        wr_o.idx = addr_q;
      end else begin
        wr_o.wr  = 1'b1;
        wr_o.hi  = hi_q;
        wr_o.idx = addr_q;
        hi_d     = ~hi_q;
        if (hi_q) begin
          addr_d = (addr_q >= LAST_IDX) ? start_q : addr_q + 1'b1;
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_MANUAL;
      hi_q    <= 1'b0;
      addr_q  <= '0;
      start_q <= '0;
    end else if (fall_i) begin
      mode_q  <= mode_d;
      hi_q    <= hi_d;
      addr_q  <= addr_d;
      start_q <= start_d;
    end
  end

  assign mode_o  = mode_q;
  assign hi_o    = hi_q;
  assign addr_o  = addr_q;
  assign start_o = start_q;
endmodule

// File: rtl/lp_reg_bank.sv
module lp_reg_bank
  import lp_pkg::*;
#(
  parameter int unsigned NREG = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  byte_wr_t                wr_i,
  input  logic [BYTE_W-1:0]       data_i,
  output logic [NREG*2*BYTE_W-1:0] regs_o
);
  localparam int unsigned REG_W = 2 * BYTE_W;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit, en_lo, en_hi;
    logic [BYTE_W-1:0] lo_q, hi_q;

    assign hit   = wr_i.wr && (wr_i.idx == BYTE_W'(g));
    assign en_lo = hit && !wr_i.hi;
    assign en_hi = hit &&  wr_i.hi;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lo_q <= '0;
      else if (en_lo) lo_q <= data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_q <= '0;
      else if (en_hi) hi_q <= data_i;
    end

    assign regs_o[g*REG_W +: REG_W] = {hi_q, lo_q};
  end
endmodule

// File: rtl/reg_load_port.sv
module reg_load_port
  import lp_pkg::*;
#(
  parameter int unsigned NREG = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic                     sel_data_i,
  input  logic                     sel_hi_i,
  input  logic [BYTE_W-1:0]        data_i,
  output logic [NREG*2*BYTE_W-1:0] regs_o
);
  logic              rst_s;
  logic              load_q;
  logic              fall;
  byte_wr_t          wr;
  mode_e             mode;
  logic              hi_phase;
  logic [BYTE_W-1:0] addr;
  logic [BYTE_W-1:0] start;

  lp_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) load_q <= 1'b0;
    else        load_q <= load_i;
  end

  assign fall = load_q & ~load_i;

  lp_addr_ctrl #(.NREG(NREG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s),
    .fall_i     (fall),
    .sel_data_i (sel_data_i),
    .sel_hi_i   (sel_hi_i),
    .data_i     (data_i),
    .wr_o       (wr),
    .mode_o     (mode),
    .hi_o       (hi_phase),
    .addr_o     (addr),
    .start_o    (start)
  );

  lp_reg_bank #(.NREG(NREG)) u_bank (
    .clk    (clk),
    .rst_n  (rst_s),
    .wr_i   (wr),
    .data_i (data_i),
    .regs_o (regs_o)
  );
endmodule

// File: rtl/reg_load_port_chk.sv
module reg_load_port_chk #(
  parameter int unsigned NREG = 19
) (
  input logic                clk,
  input logic                rst_s,
  input logic                load_q,
  input logic                load_i,
  input logic                sel_data_i,
  input logic                auto_mode,
  input logic                hi_phase,
  input logic [7:0]          addr,
  input logic [7:0]          start,
  input logic [NREG*16-1:0]  regs_o
);
  logic strobe;
  assign strobe = load_q && !load_i;

  assert_no_strobe_stable_R4: assert property (@(posedge clk) disable iff (!rst_s)
    !strobe |=> $stable(regs_o));

  assert_addr_write_no_data_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (strobe && !sel_data_i) |=> $stable(regs_o));

  assert_manual_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (strobe && sel_data_i && !auto_mode) |=> $stable(addr));

  assert_manual_out_of_range_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (strobe && sel_data_i && !auto_mode && addr >= 8'(NREG)) |=> $stable(regs_o));

  assert_phase_toggle_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (strobe && sel_data_i && auto_mode) |=> (hi_phase != $past(hi_phase)));

  assert_wrap_to_start_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (strobe && sel_data_i && auto_mode && hi_phase && addr >= 8'(NREG - 1)) |=> (addr == start));

  assert_rearm_phase_low_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (strobe && !sel_data_i) |=> !hi_phase);
endmodule

bind reg_load_port reg_load_port_chk #(.NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .load_q     (load_q),
  .load_i     (load_i),
  .sel_data_i (sel_data_i),
  .auto_mode  (mode == lp_pkg::MODE_AUTO),
  .hi_phase   (hi_phase),
  .addr       (addr),
  .start      (start),
  .regs_o     (regs_o)
);

// File: tb/reg_load_port_tb.sv
module reg_load_port_tb;
  localparam int NREG = 19;

  logic clk = 1'b0;
  logic rst_n;
  logic load = 1'b0, sd = 1'b0, hi = 1'b0;
  logic [7:0] data = '0;
  logic [NREG*16-1:0] regs;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_reg [NREG];
  int m_addr, m_start;
  bit m_auto, m_hi, m_lq;

  always #2 clk = ~clk;

  reg_load_port u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load), .sel_data_i(sd),
    .sel_hi_i(hi), .data_i(data), .regs_o(regs)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input int i);
    return regs[i*16 +: 16];
  endfunction

  task automatic mwrite(input int a, input bit h, input logic [7:0] d);
    if (a < NREG) begin
      if (h) m_reg[a][15:8] = d;
      else   m_reg[a][7:0]  = d;
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = '0;
      m_addr = 0; m_start = 0; m_auto = 0; m_hi = 0; m_lq = 0;
    end else begin
      if (m_lq && !load) begin
        if (!sd) begin
          m_addr = data; m_start = data; m_auto = hi; m_hi = 0;
        end else if (!m_auto) begin
          mwrite(m_addr, hi, data);
        end else begin
          mwrite(m_addr, m_hi, data);
          if (m_hi) begin
            m_hi = 0;
            m_addr = (m_addr >= NREG - 1) ? m_start : m_addr + 1;
          end else m_hi = 1;
        end
      end
      m_lq = load;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      for (int i = 0; i < NREG; i++) chk($sformatf("R10 model reg%0d", i), rd(i), m_reg[i]);
    end
  end

  task automatic ld(input bit s, input bit h, input logic [7:0] d);
    @(negedge clk);
    sd = s; hi = h; data = d; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < NREG; i++) chk("R1 reset value", rd(i), 16'h0000);
    ld(1, 0, 8'h5A);                       // manual, address 0 from reset
    chk("R1 manual after reset", rd(0), 16'h005A);

    // R2 manual addressing
    ld(0, 0, 8'd3);
    ld(1, 0, 8'h34);
    ld(1, 1, 8'h12);
    chk("R2 manual lo+hi", rd(3), 16'h1234);
    ld(1, 0, 8'h56);
    chk("R2 address held", rd(3), 16'h1256);
    chk("R2 next reg untouched", rd(4), 16'h0000);

    // R4 only the falling edge transfers
    @(negedge clk); sd = 1; hi = 0; data = 8'hAA; load = 1;
    repeat (4) @(negedge clk);
    chk("R4 strobe high no write", rd(3), 16'h1256);
    load = 0; @(negedge clk);
    chk("R4 falling edge writes", rd(3), 16'h12AA);

    // R3 out-of-range manual address
    ld(0, 0, 8'd19);
    ld(1, 0, 8'hFF);
    ld(1, 1, 8'hEE);
    chk("R3 ignored reg18", rd(18), 16'h0000);
    chk("R3 ignored reg3", rd(3), 16'h12AA);

    // R5 arm auto at 15
    ld(0, 1, 8'd15);
    chk("R5 arm writes nothing", rd(15), 16'h0000);

    // R6/R7 auto fill and wrap to start
    for (int k = 0; k < 10; k++) ld(1, (k % 2 == 0), 8'(8'h10 + k));
    chk("R6 low then high reg16", rd(16), 16'h1312);
    chk("R6 reg18", rd(18), 16'h1716);
    chk("R7 wrap to start reg15", rd(15), 16'h1918);
    chk("R7 below start untouched", rd(14), 16'h0000);

    // R8 start at top and beyond
    ld(0, 1, 8'd18);
    ld(1, 0, 8'hA1); ld(1, 0, 8'hA2); ld(1, 0, 8'hA3); ld(1, 0, 8'hA4);
    chk("R8 repeat on 18", rd(18), 16'hA4A3);
    chk("R8 no spill to start", rd(15), 16'h1918);
    ld(0, 1, 8'd25);
    ld(1, 0, 8'hB1); ld(1, 0, 8'hB2); ld(1, 0, 8'hB3);
    chk("R8 start 25 ignored", rd(18), 16'hA4A3);

    // R9 re-arm mid pair
    ld(0, 1, 8'd2);
    ld(1, 0, 8'hEE);
    ld(0, 1, 8'd2);
    ld(1, 1, 8'h01); ld(1, 0, 8'h02);
    chk("R9 phase restarts low", rd(2), 16'h0201);
    ld(0, 1, 8'd0);
    ld(1, 0, 8'h77);
    ld(0, 0, 8'd1);
    ld(1, 1, 8'h88);
    chk("R9 switch to manual", rd(1), 16'h8800);
    chk("R9 half pair kept", rd(0)[7:0], 8'h77);

    // R10 full programming in 39 strobes
    do_reset();
    ld(0, 1, 8'd0);
    for (int k = 0; k < 2 * NREG; k++) ld(1, 0, 8'((k * 7 + 3) & 8'hFF));
    for (int i = 0; i < NREG; i++)
      chk("R10 full bank", rd(i), {8'(((2*i+1) * 7 + 3) & 8'hFF), 8'(((2*i) * 7 + 3) & 8'hFF)});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule